// File: doc/BRIEF.md
# Rotor Cipher Letter Sequencer

This block enciphers one letter at a time in the manner of a rotor machine. A letter code (0 to 25) arrives with a start strobe. A controlling state machine then steers the letter through one shared datapath on a fixed schedule: a plugboard swap, a forward pass through the active wheels, a reflector, a return pass through the same wheels in reverse order, and a final plugboard swap. The shared datapath holds one 5-bit modular adder, built from chained 3-bit carry-lookahead groups, and the constant wiring tables. The result comes back with a one-cycle done pulse, and the wheel positions then advance in odometer fashion.

A mode input selects three or four wheels. The wheel positions are loaded from a packed input bus while the engine is idle. Between letters they are kept and stepped internally, so a stream of letters follows the usual rotor stepping sequence. Every pass through a wheel takes two cycles. The first adds the wheel position and indexes the wiring table. The second subtracts the position again.

States: IDLE (waits for start), PLUG (first plugboard swap), FWD_ADD / FWD_SUB (forward wheel steps), REFL (reflector), BWD_ADD / BWD_SUB (return wheel steps), OUT (final swap, result register, wheel stepping). Transitions: IDLE→PLUG on start; PLUG→FWD_ADD; FWD_ADD→FWD_SUB; FWD_SUB→FWD_ADD on the next wheel, or →REFL after the last active wheel; REFL→BWD_ADD; BWD_ADD→BWD_SUB; BWD_SUB→BWD_ADD on the previous wheel, or →OUT after wheel 0; OUT→IDLE.

Top module: `rotor_seq`

## Requirements
- R1: After reset, done is 0, letter_out is 0 and all four wheel positions are 0.
- R2: A start seen while idle accepts letter_in and latches four_wheels. Codes 26 to 31 are treated as the code minus 26.
- R3: The number of active wheels N is 3 when four_wheels is 0 (wheels 0 to 2) and 4 when it is 1. Counting the start cycle as cycle 1, done is high in cycle 4N+5: cycle 17 for three wheels and cycle 21 for four.
- R4: Done is high for exactly one cycle. letter_out carries the result in that cycle and keeps it until the next result.
- R5: The cipher proceeds in this order. First the plugboard. Then for w = 0 to N-1: x = F_w((x+p_w) mod 26), followed by x = (x-p_w) mod 26. Then the reflector. Then for w = N-1 down to 0, the same two steps with the inverse table of F_w. Finally the plugboard again.
- R6: The tables are as follows. F_w(x) = (a_w·x + b_w) mod 26, with a = 3,5,7,9 and b = 1,4,9,16 for wheels 0,1,2,3. The reflector maps x to x XOR 1. The plugboard swaps 0↔13, 1↔14 and 2↔15 and leaves every other letter unchanged.
- R7: After each letter, wheel 0 advances by one modulo 26. Wheel i advances only when wheel i-1 wraps from 25 to 0. In three-wheel mode wheel 3 never moves.
- R8: pos_load while idle loads wheel i from pos_in[5i+4:5i]. Values 26 to 31 are reduced by 26.
- R9: While the engine is busy, start and pos_load are ignored. No extra result appears and the positions are unchanged.
- R10: With equal positions and mode, enciphering the result gives the original letter back, and no letter ever maps to itself.
- R11: The offset sum is formed by a 6-bit adder made of two chained 3-bit carry-lookahead groups. Its modular result always equals (a±b) mod 26.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a letter (honoured only when idle) |
| letter_in | input | 5 | Plain letter code |
| four_wheels | input | 1 | 1 selects four wheels, 0 selects three |
| pos_load | input | 1 | Load wheel positions (honoured only when idle) |
| pos_in | input | 20 | Packed positions, wheel i at bits 5i+4:5i |
| done | output | 1 | One-cycle result strobe |
| letter_out | output | 5 | Enciphered letter |

## Verification
The bench builds the block with its default parameters: four wheel slots and 5-bit letters. Both three-wheel and four-wheel modes are therefore reachable, and the bench checks the 17-cycle and 21-cycle schedules. The bench loads positions next to 25, so wheel-carry cascades and the held fourth wheel in three-wheel mode occur within a few letters. Pokes in the middle of a run, and re-enciphering a letter after its starting positions are reloaded, exercise the busy-ignore rule and the reciprocal property.

// File: rtl/rotor_pkg.sv
package rotor_pkg;
    localparam int SYM_W = 5;
    localparam int ALPHA = 26;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [2:0] {
        S_IDLE, S_PLUG, S_FWD_ADD, S_FWD_SUB,
        S_REFL, S_BWD_ADD, S_BWD_SUB, S_OUT
    } phase_e;

    // Reduce a code in 26..31 back into the alphabet.
    function automatic sym_t fold(input sym_t x);
        return (int'(x) >= ALPHA) ? sym_t'(int'(x) - ALPHA) : x;
    endfunction

    // Affine wheel wiring: multiplier coprime to 26, so the map is a permutation.
    function automatic sym_t wheel_fwd(input int w, input sym_t x);
        int a;
        int b;
        case (w)
            0:       begin a = 3; b = 1;  end
            1:       begin a = 5; b = 4;  end
            2:       begin a = 7; b = 9;  end
            default: begin a = 9; b = 16; end
        endcase
        return sym_t'((a * int'(x) + b) % ALPHA);
    endfunction

    function automatic sym_t wheel_inv(input int w, input sym_t y);
        int ai;
        int b;
        case (w)
            0:       begin ai = 9;  b = 1;  end
            1:       begin ai = 21; b = 4;  end
            2:       begin ai = 15; b = 9;  end
            default: begin ai = 3;  b = 16; end
        endcase
        return sym_t'((ai * ((int'(y) + ALPHA - b) % ALPHA)) % ALPHA);
    endfunction

    function automatic sym_t reflect(input sym_t x);
        return x ^ sym_t'(1);
    endfunction

    function automatic sym_t plug_swap(input sym_t x);
        if (int'(x) < 3)
            return sym_t'(int'(x) + 13);
        else if (int'(x) >= 13 && int'(x) < 16)
            return sym_t'(int'(x) - 13);
        else
            return x;
    endfunction
endpackage

// File: rtl/rotor_cla.sv
module rotor_cla #(
    parameter int W = 6,
    parameter int G = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s
);
    localparam int NG = W / G;

    logic [NG:0] cin;
    assign cin[0] = 1'b0;

    for (genvar k = 0; k < NG; k++) begin : g_grp
        logic [G-1:0] sg;
        logic         gg;
        logic         gp;
        always_comb begin
            logic c;
            c  = cin[k];
            gg = 1'b0;
            gp = 1'b1;
            for (int j = 0; j < G; j++) begin
                sg[j] = a[k*G+j] ^ b[k*G+j] ^ c;
                c     = (a[k*G+j] & b[k*G+j]) | ((a[k*G+j] ^ b[k*G+j]) & c);
                gg    = (a[k*G+j] & b[k*G+j]) | ((a[k*G+j] ^ b[k*G+j]) & gg);
                gp    = gp & (a[k*G+j] ^ b[k*G+j]);
            end
        end
        assign s[k*G +: G] = sg;
        // group lookahead carry into the next group
        assign cin[k+1] = gg | (gp & cin[k]);
    end
endmodule

// File: rtl/rotor_modunit.sv
module rotor_modunit #(
    parameter int W = 5,
    parameter int A = 26,
    parameter int G = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    localparam int SW = W + 1;

    logic [SW-1:0] b_eff;
    logic [SW-1:0] sum;

    // subtraction as addition of the complement against the modulus
    assign b_eff = sub ? (SW'(A) - {1'b0, b}) : {1'b0, b};

    rotor_cla #(.W(SW), .G(G)) u_cla (
        .a ({1'b0, a}),
        .b (b_eff),
        .s (sum)
    );

    assign y = (sum >= SW'(A)) ? W'(sum - SW'(A)) : W'(sum);

    always_comb begin
        if (int'(a) < A && int'(b) < A) begin
            p_mod_result_r11: assert (int'(y) ==
                (sub ? ((int'(a) - int'(b) + A) % A) : ((int'(a) + int'(b)) % A)));
        end
    end
endmodule

// File: rtl/rotor_stepper.sv
module rotor_stepper #(
    parameter int W = 5,
    parameter int N = 4,
    parameter int A = 26
) (
    input  logic [N*W-1:0] cur_i,
    input  logic           all_i,
    output logic [N*W-1:0] nxt_o
);
    logic [N-1:0] cy;
    assign cy[0] = 1'b1;

    for (genvar i = 0; i < N; i++) begin : g_wheel
        logic act;
        logic at_top;
        if (i < N - 1) begin : g_always
            assign act = 1'b1;
        end else begin : g_mode
            assign act = all_i;
        end
        assign at_top = (cur_i[i*W +: W] == W'(A - 1));
        assign nxt_o[i*W +: W] = (cy[i] & act)
                               ? (at_top ? '0 : cur_i[i*W +: W] + W'(1))
                               : cur_i[i*W +: W];
        if (i < N - 1) begin : g_carry
            assign cy[i+1] = cy[i] & act & at_top;
        end
    end
endmodule

// File: rtl/rotor_seq.sv
module rotor_seq
    import rotor_pkg::*;
#(
    parameter int LETTER_W = rotor_pkg::SYM_W,
    parameter int WHEELS   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [LETTER_W-1:0]          letter_in,
    input  logic                         four_wheels,
    input  logic                         pos_load,
    input  logic [WHEELS*LETTER_W-1:0]   pos_in,
    output logic                         done,
    output logic [LETTER_W-1:0]          letter_out
);
    localparam int IDX_W = $clog2(WHEELS);
    localparam int POS_W = WHEELS * LETTER_W;
    localparam int CNT_W = $clog2(4 * WHEELS + 8);

    phase_e           state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] last_idx;
    sym_t             cur_q, cur_d;
    logic             four_q;
    sym_t             pos_q [WHEELS];
    logic [POS_W-1:0] pos_flat;
    logic [POS_W-1:0] step_flat;
    sym_t             mod_y;
    logic             mod_sub;

    for (genvar i = 0; i < WHEELS; i++) begin : g_flat
        assign pos_flat[i*LETTER_W +: LETTER_W] = pos_q[i];
    end

    assign last_idx = four_q ? IDX_W'(WHEELS - 1) : IDX_W'(WHEELS - 2);
    assign mod_sub  = (state_q == S_FWD_SUB) || (state_q == S_BWD_SUB);

    rotor_modunit #(.W(LETTER_W), .A(ALPHA), .G(3)) u_mod (
        .a   (cur_q),
        .b   (pos_q[idx_q]),
        .sub (mod_sub),
        .y   (mod_y)
    );

    rotor_stepper #(.W(LETTER_W), .N(WHEELS), .A(ALPHA)) u_step (
        .cur_i (pos_flat),
        .all_i (four_q),
        .nxt_o (step_flat)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next-state and wheel index
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_PLUG;
            S_PLUG:    begin state_d = S_FWD_ADD; idx_d = '0; end
            S_FWD_ADD: state_d = S_FWD_SUB;
            S_FWD_SUB: begin
                if (idx_q == last_idx) state_d = S_REFL;
                else begin state_d = S_FWD_ADD; idx_d = idx_q + IDX_W'(1); end
            end
            S_REFL:    state_d = S_BWD_ADD;
            S_BWD_ADD: state_d = S_BWD_SUB;
            S_BWD_SUB: begin
                if (idx_q == '0) state_d = S_OUT;
                else begin state_d = S_BWD_ADD; idx_d = idx_q - IDX_W'(1); end
            end
            S_OUT:     state_d = S_IDLE;
        endcase
    end

    // datapath letter per phase
    always_comb begin
        cur_d = cur_q;
        unique case (state_q)
            S_IDLE:    if (start) cur_d = fold(letter_in);
            S_PLUG:    cur_d = plug_swap(cur_q);
            S_FWD_ADD: cur_d = wheel_fwd(int'(idx_q), mod_y);
            S_FWD_SUB: cur_d = mod_y;
            S_REFL:    cur_d = reflect(cur_q);
            S_BWD_ADD: cur_d = wheel_inv(int'(idx_q), mod_y);
            S_BWD_SUB: cur_d = mod_y;
            S_OUT:     cur_d = cur_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            four_q     <= 1'b0;
            done       <= 1'b0;
            letter_out <= '0;
            for (int i = 0; i < WHEELS; i++) pos_q[i] <= '0;
        end else begin
            cur_q <= cur_d;
            done  <= (state_q == S_OUT);
            if (state_q == S_IDLE && start) four_q <= four_wheels;
            if (state_q == S_OUT) begin
                letter_out <= plug_swap(cur_q);
                for (int i = 0; i < WHEELS; i++)
                    pos_q[i] <= step_flat[i*LETTER_W +: LETTER_W];
            end else if (state_q == S_IDLE && pos_load) begin
                for (int i = 0; i < WHEELS; i++)
                    pos_q[i] <= fold(pos_in[i*LETTER_W +: LETTER_W]);
            end
        end
    end

    // cycle count since acceptance, used only by the latency check
    logic [CNT_W-1:0] lat_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           lat_cnt <= '0;
        else if (state_q == S_IDLE && start)  lat_cnt <= CNT_W'(1);
        else if (state_q != S_IDLE)           lat_cnt <= lat_cnt + CNT_W'(1);
    end

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_cnt == (four_q ? CNT_W'(4*WHEELS + 4) : CNT_W'(4*(WHEELS-1) + 4))));

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_out_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(letter_out) < ALPHA));

    p_pos_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_OUT && !(state_q == S_IDLE && pos_load)) |=> $stable(pos_flat));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> (state_q != S_PLUG));
endmodule

// File: tb/rotor_seq_bench.sv
`timescale 1ns/1ps
module rotor_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  letter_in = '0;
    logic        four_wheels = 1'b0;
    logic        pos_load = 1'b0;
    logic [19:0] pos_in = '0;
    logic        done;
    logic [4:0]  letter_out;

    int total = 0;
    int bad = 0;
    int mp [4];
    int last_out = 0;

    always #4 clk = ~clk;

    rotor_seq u_rotor_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .letter_in(letter_in),
        .four_wheels(four_wheels), .pos_load(pos_load), .pos_in(pos_in),
        .done(done), .letter_out(letter_out)
    );

    // stimulus table: {mode, letter}
    localparam logic [5:0] VEC [10] = '{
        {1'b0, 5'd0},  {1'b0, 5'd25}, {1'b1, 5'd13}, {1'b1, 5'd7},
        {1'b0, 5'd1},  {1'b1, 5'd14}, {1'b0, 5'd20}, {1'b1, 5'd2},
        {1'b0, 5'd15}, {1'b1, 5'd24}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // independent model built from the requirement text
    function automatic int m_plug(input int x);
        if (x < 3) return x + 13;
        if (x >= 13 && x < 16) return x - 13;
        return x;
    endfunction

    function automatic int m_fwd(input int w, input int x);
        int a [4] = '{3, 5, 7, 9};
        int b [4] = '{1, 4, 9, 16};
        return (a[w] * x + b[w]) % 26;
    endfunction

    function automatic int m_inv(input int w, input int y);
        for (int z = 0; z < 26; z++) if (m_fwd(w, z) == y) return z;
        return 0;
    endfunction

    function automatic int m_enc(input int l, input bit fw);
        int n = fw ? 4 : 3;
        int x = m_plug(l);
        for (int w = 0; w < n; w++) begin
            x = m_fwd(w, (x + mp[w]) % 26);
            x = (x - mp[w] + 26) % 26;
        end
        x = x ^ 1;
        for (int w = n - 1; w >= 0; w--) begin
            x = m_inv(w, (x + mp[w]) % 26);
            x = (x - mp[w] + 26) % 26;
        end
        return m_plug(x);
    endfunction

    task automatic m_step(input bit fw);
        bit carry = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (carry && (i < 3 || fw)) begin
                if (mp[i] == 25) mp[i] = 0;
                else begin mp[i] = mp[i] + 1; carry = 1'b0; end
            end else carry = 1'b0;
        end
    endtask

    task automatic load_pos(input int p0, input int p1, input int p2, input int p3);
        @(negedge clk);
        pos_load = 1'b1;
        pos_in = {5'(p3), 5'(p2), 5'(p1), 5'(p0)};
        @(posedge clk);
        @(negedge clk);
        pos_load = 1'b0;
        mp[0] = (p0 >= 26) ? p0 - 26 : p0;
        mp[1] = (p1 >= 26) ? p1 - 26 : p1;
        mp[2] = (p2 >= 26) ? p2 - 26 : p2;
        mp[3] = (p3 >= 26) ? p3 - 26 : p3;
    endtask

    // one letter; checks latency (R3), value, pulse width and hold (R4)
    task automatic send(input int l, input bit fw, input string req, input bit poke);
        int n = fw ? 4 : 3;
        int exp = m_enc((l >= 26) ? l - 26 : l, fw);
        m_step(fw);
        @(negedge clk);
        start = 1'b1;
        letter_in = 5'(l);
        four_wheels = fw;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int e = 1; e <= 4 * n + 3; e++) begin
            if (poke && e == 3) begin
                start = 1'b1;
                letter_in = 5'(l ^ 5);
                pos_load = 1'b1;
                pos_in = {4{5'd7}};
            end
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            pos_load = 1'b0;
            if (e == 4 * n + 2) chk(done == 1'b0, "R3 early", int'(done), 0);
            if (e == 4 * n + 3) begin
                chk(done == 1'b1, "R3 on time", int'(done), 1);
                chk(int'(letter_out) == exp, req, int'(letter_out), exp);
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R4 pulse", int'(done), 0);
        chk(int'(letter_out) == exp, "R4 hold", int'(letter_out), exp);
        last_out = int'(letter_out);
        if (poke) begin
            bit seen = 1'b0;
            for (int k = 0; k < 4 * n + 6; k++) begin
                @(posedge clk);
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            chk(!seen, "R9 no extra result", int'(seen), 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int y;
        for (int i = 0; i < 4; i++) mp[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(letter_out == 5'd0, "R1 letter_out", int'(letter_out), 0);
        rst_n = 1'b1;
        // R1: positions start at zero, no load issued
        send(4, 1'b0, "R1 zero positions", 1'b0);

        // table walk across a carry cascade (R5 R6 R7 R11)
        load_pos(24, 25, 0, 3);
        for (int v = 0; v < 10; v++)
            send(int'(VEC[v][4:0]), VEC[v][5], "R5 R6 R7 R11 vector", 1'b0);

        // R7: wheel 3 holds in three-wheel mode during a full cascade
        load_pos(25, 25, 25, 10);
        send(7, 1'b0, "R7 cascade", 1'b0);
        send(7, 1'b1, "R7 wheel3 held", 1'b0);

        // R2: out-of-range letter folds
        load_pos(5, 6, 7, 8);
        send(27, 1'b0, "R2 fold letter", 1'b0);
        send(31, 1'b1, "R2 fold letter", 1'b0);

        // R8: out-of-range positions fold
        load_pos(30, 26, 31, 3);
        send(9, 1'b1, "R8 fold position", 1'b0);

        // R9: start and pos_load ignored while busy
        load_pos(1, 2, 3, 4);
        send(9, 1'b1, "R9 busy poke", 1'b1);
        send(2, 1'b1, "R9 positions kept", 1'b0);

        // R10: reciprocal with equal positions
        load_pos(3, 8, 12, 20);
        send(11, 1'b1, "R10 first", 1'b0);
        y = last_out;
        chk(y != 11, "R10 no fixed point", y, 11);
        load_pos(3, 8, 12, 20);
        send(y, 1'b1, "R10 reciprocal", 1'b0);
        chk(last_out == 11, "R10 round trip", last_out, 11);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule